// File: doc/BRIEF.md
# Transmit Fabric Width Adapter

This block sits between user logic and a 4-byte transmit core and moves user data of a run-time selectable width onto the fixed core width. Each byte travels with one control-flag bit. A 2-bit width code picks 1, 2, 4 or 8 bytes per user word. Narrow words (1 or 2 bytes) are gathered into full 4-byte core words. A 4-byte word passes straight through. An 8-byte word is split into two core words.

The user clock and the core clock are frequency-related and phase-aligned. Both are modelled as one fast clock `clk`, with a user-side enable `userEn` and a core-side enable `coreEn`. The width setting fixes the ratio between the two enables:

| Width code | userEn rate | coreEn rate |
|---|---|---|
| 1 byte | every cycle | every fourth cycle |
| 2 bytes | every cycle | every second cycle |
| 4 bytes | every cycle | every cycle |
| 8 bytes | every second cycle | every cycle |

Within a core period, `coreEn` falls on the last cycle. The width code is held steady between resets.

Top module: `txwidth_adapter`

## Requirements
- R1: While reset is low, and at the first sample after it is released, `coreValid`, `coreData` and `coreCtl` are all zero.
- R2: The width code selects the bytes per user word: 00 = 1, 01 = 2, 10 = 4, 11 = 8. A word is taken from the low bytes of `userData` and `userCtl` on a `userEn` cycle. Every accepted byte reaches the core side exactly once, and higher unused lanes have no effect.
- R3: In 1-byte mode, four consecutive user bytes form one core word. The first-accepted byte lands in bits 7:0, and later bytes fill the higher lanes in order.
- R4: In 2-byte mode, two consecutive user words form one core word. The first word fills lanes 0 and 1 (bits 15:0).
- R5: In 4-byte mode, each user word appears unchanged as one core word.
- R6: In 8-byte mode, `userData[31:0]` is emitted first and `userData[63:32]` is emitted at the next core enable.
- R7: Each control flag travels with its byte: bit k of `coreCtl` belongs to the byte in `coreData` bits 8k+7:8k.
- R8: `coreValid`, `coreData` and `coreCtl` change only on cycles with `coreEn` high.
- R9: A core word becomes visible at the first `coreEn` edge strictly after the edge that accepted its last byte. `coreValid` is high for that one core period. At a `coreEn` edge with nothing assembled, `coreValid` goes low.
- R10: Under the enable ratios above, no assembled word is overwritten before it is emitted, and no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by both sides |
| rstN | input | 1 | Active-low synchronous reset |
| widthSel | input | 2 | User word width code (00 = 1, 01 = 2, 10 = 4, 11 = 8 bytes) |
| userEn | input | 1 | User-side clock enable; a user word is accepted when high |
| userData | input | 64 | User bytes, lane 0 in bits 7:0 |
| userCtl | input | 8 | Per-byte control flags of the user word |
| coreEn | input | 1 | Core-side clock enable |
| coreData | output | 32 | Core word, lane 0 in bits 7:0 |
| coreCtl | output | 4 | Per-byte control flags of the core word |
| coreValid | output | 1 | Core word holds a freshly assembled word for this core period |

## Verification
The word that completes on a given user edge is placed in the holding stage on that same edge. It is therefore due at the first later `coreEn` edge, which is one core period later in the narrow modes and one cycle later in the wide modes. The two halves of an 8-byte word come out at two consecutive core edges.

The bench records the edge number at which it drives each completing byte. After every `coreEn` edge it expects `coreValid` exactly when the oldest pending word completed at an earlier edge, and it compares that word. All sampling happens at the falling edge that follows the rising edge, so each result is read one half cycle after the register that produces it updates. After edges without `coreEn`, the bench checks that all three outputs kept their previous values.

// File: rtl/txwidth_pkg.sv
package txwidth_pkg;
  localparam int BYTE_W     = 8;
  localparam int CORE_BYTES = 4;
  localparam int USER_BYTES = 2 * CORE_BYTES;
  localparam int FILL_W     = $clog2(CORE_BYTES);
  localparam int SEL_W      = $clog2(USER_BYTES);

  // strobes from control to datapath
  typedef struct packed {
    logic              accWrite;
    logic [FILL_W-1:0] wrOffset;
    logic [FILL_W:0]   wrBytes;
    logic              loadNarrow;
    logic              loadWide;
    logic              emit;
    logic              emitHigh;
  } stb_t;
endpackage

// File: rtl/txwidth_ctrl.sv
module txwidth_ctrl
  import txwidth_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] widthSel,
  input  logic       userEn,
  input  logic       coreEn,
  output stb_t       stb,
  output logic       coreValid
);
  localparam logic [1:0] WIDE_CODE = 2'b11;

  logic [FILL_W-1:0] fillCnt;
  logic [1:0]        pendCnt;
  logic              holdWide;
  logic [FILL_W:0]   userBytes;
  logic [FILL_W:0]   fillSum;

  always_comb begin
    userBytes      = (FILL_W+1)'(1) << widthSel;
    fillSum        = {1'b0, fillCnt} + userBytes;
    stb            = '0;
    stb.wrOffset   = fillCnt;
    stb.wrBytes    = userBytes;
    if (userEn) begin
      if (widthSel == WIDE_CODE) begin
        stb.loadWide = 1'b1;
      end else begin
        stb.accWrite   = 1'b1;
        stb.loadNarrow = (fillSum == (FILL_W+1)'(CORE_BYTES));
      end
    end
    stb.emit     = coreEn && (pendCnt != 2'd0);
    stb.emitHigh = holdWide && (pendCnt == 2'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt   <= '0;
      pendCnt   <= 2'd0;
      holdWide  <= 1'b0;
      coreValid <= 1'b0;
    end else begin
      if (stb.accWrite) fillCnt <= fillSum[FILL_W-1:0];
      if (stb.loadWide) begin
        pendCnt  <= 2'd2;
        holdWide <= 1'b1;
      end else if (stb.loadNarrow) begin
        pendCnt  <= 2'd1;
        holdWide <= 1'b0;
      end else if (stb.emit) begin
        pendCnt  <= pendCnt - 2'd1;
      end
      if (coreEn) coreValid <= (pendCnt != 2'd0);
    end
  end

  // R10: a load may only land on an empty hold stage or one draining now
  assert_no_overrun_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadWide || stb.loadNarrow) |-> (pendCnt == 2'd0 || (pendCnt == 2'd1 && stb.emit)));

  // R8: valid only moves on core enable
  assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !coreEn |=> $stable(coreValid));

  // R9: an emitted word is flagged valid
  assert_emit_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |=> coreValid);

  // R3: a completed narrow word restarts packing at lane 0
  assert_narrow_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadNarrow |=> fillCnt == '0);
endmodule

// File: rtl/txwidth_datapath.sv
module txwidth_datapath
  import txwidth_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  stb_t                           stb,
  input  logic [USER_BYTES*BYTE_W-1:0]   userData,
  input  logic [USER_BYTES-1:0]          userCtl,
  output logic [CORE_BYTES*BYTE_W-1:0]   coreData,
  output logic [CORE_BYTES-1:0]          coreCtl
);
  logic [USER_BYTES-1:0][BYTE_W-1:0] userLane;
  logic [CORE_BYTES-1:0][BYTE_W-1:0] accQ, accNext;
  logic [CORE_BYTES-1:0]             accCtlQ, accCtlNext;
  logic [USER_BYTES-1:0][BYTE_W-1:0] holdQ;
  logic [USER_BYTES-1:0]             holdCtlQ;
  logic [SEL_W-1:0]                  srcIdx;

  assign userLane = userData;

  // merge the incoming user bytes into the lanes starting at the fill offset
  always_comb begin
    accNext    = accQ;
    accCtlNext = accCtlQ;
    srcIdx     = '0;
    for (int b = 0; b < CORE_BYTES; b++) begin
      if (b >= int'(stb.wrOffset) && b < int'(stb.wrOffset) + int'(stb.wrBytes)) begin
        srcIdx        = SEL_W'(b) - SEL_W'(stb.wrOffset);
        accNext[b]    = userLane[srcIdx];
        accCtlNext[b] = userCtl[srcIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= '0;
      accCtlQ  <= '0;
      holdQ    <= '0;
      holdCtlQ <= '0;
      coreData <= '0;
      coreCtl  <= '0;
    end else begin
      if (stb.accWrite) begin
        accQ    <= accNext;
        accCtlQ <= accCtlNext;
      end
      if (stb.loadWide) begin
        holdQ    <= userLane;
        holdCtlQ <= userCtl;
      end else if (stb.loadNarrow) begin
        holdQ[CORE_BYTES-1:0]    <= accNext;
        holdCtlQ[CORE_BYTES-1:0] <= accCtlNext;
      end
      if (stb.emit) begin
        if (stb.emitHigh) begin
          coreData <= holdQ[USER_BYTES-1:CORE_BYTES];
          coreCtl  <= holdCtlQ[USER_BYTES-1:CORE_BYTES];
        end else begin
          coreData <= holdQ[CORE_BYTES-1:0];
          coreCtl  <= holdCtlQ[CORE_BYTES-1:0];
        end
      end
    end
  end

  // R6: a low-half emit presents the lower hold lanes
  assert_low_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && !stb.emitHigh) |=> coreData == $past(holdQ[CORE_BYTES-1:0]));

  // R8: core word frozen between emits
  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.emit |=> ($stable(coreData) && $stable(coreCtl)));
endmodule

// File: rtl/txwidth_adapter.sv
module txwidth_adapter
  import txwidth_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   widthSel,
  input  logic                         userEn,
  input  logic [USER_BYTES*BYTE_W-1:0] userData,
  input  logic [USER_BYTES-1:0]        userCtl,
  input  logic                         coreEn,
  output logic [CORE_BYTES*BYTE_W-1:0] coreData,
  output logic [CORE_BYTES-1:0]        coreCtl,
  output logic                         coreValid
);
  stb_t stb;

  txwidth_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .widthSel  (widthSel),
    .userEn    (userEn),
    .coreEn    (coreEn),
    .stb       (stb),
    .coreValid (coreValid)
  );

  txwidth_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .userData (userData),
    .userCtl  (userCtl),
    .coreData (coreData),
    .coreCtl  (coreCtl)
  );
endmodule

// File: tb/txwidth_adapter_tb.sv
`timescale 1ns/1ps
module txwidth_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  widthSel;
  logic        userEn, coreEn;
  logic [63:0] userData;
  logic [7:0]  userCtl;
  logic [31:0] coreData;
  logic [3:0]  coreCtl;
  logic        coreValid;

  int errors = 0;
  int checks = 0;
  int edgeNo = 0;

  logic [31:0] expData [0:63];
  logic [3:0]  expCtl  [0:63];
  int          expDone [0:63];
  int head, tail;

  always #4 clk = ~clk;
  always @(posedge clk) edgeNo <= edgeNo + 1;

  txwidth_adapter dut_i (
    .clk(clk), .rstN(rstN), .widthSel(widthSel), .userEn(userEn),
    .userData(userData), .userCtl(userCtl), .coreEn(coreEn),
    .coreData(coreData), .coreCtl(coreCtl), .coreValid(coreValid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int i, input int m);
    return 8'((i * 37 + m * 11 + 5) & 255);
  endfunction

  function automatic logic cval(input int i, input int m);
    return ((i % 3) == 0) ^ ((m % 2) == 1);
  endfunction

  task automatic runMode(input int w);
    int bytesPer, uP, cP, nWords, sent, byteIdx;
    bit prevCoreEn, lastV, expV;
    logic [31:0] lastD, wd;
    logic [3:0] lastC, wc;
    string dTag;
    bytesPer = 1 << w;
    uP = (w == 3) ? 2 : 1;
    cP = (w == 0) ? 4 : (w == 1) ? 2 : 1;
    nWords = 64 / bytesPer;
    dTag = (w == 0) ? "R3" : (w == 1) ? "R4" : (w == 2) ? "R5" : "R6";
    @(negedge clk);
    rstN = 1'b0; widthSel = 2'(w); userEn = 1'b0; coreEn = 1'b0;
    userData = '0; userCtl = '0;
    repeat (3) @(negedge clk);
    chk(coreValid == 1'b0 && coreData == '0 && coreCtl == '0, "R1 in reset",
        {31'd0, coreValid, coreData}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(coreValid == 1'b0 && coreData == '0 && coreCtl == '0, "R1 after release",
        {31'd0, coreValid, coreData}, 64'd0);
    head = 0; tail = 0; sent = 0; byteIdx = 0; prevCoreEn = 1'b0;
    for (int c = 0; c < 300; c++) begin
      if (c > 0) begin
        if (prevCoreEn) begin
          expV = (head < tail) && (expDone[head] < edgeNo);
          chk(coreValid == expV, "R9 valid timing", 64'(coreValid), 64'(expV));
          if (expV && coreValid) begin
            chk(coreData == expData[head], dTag, 64'(coreData), 64'(expData[head]));
            chk(coreCtl == expCtl[head], "R7 control lanes", 64'(coreCtl), 64'(expCtl[head]));
            head++;
          end
        end else begin
          chk(coreValid == lastV && coreData == lastD && coreCtl == lastC,
              "R8 outputs steady", {27'd0, coreCtl, coreValid, coreData},
              {27'd0, lastC, lastV, lastD});
        end
      end
      lastV = coreValid; lastD = coreData; lastC = coreCtl;
      userEn = ((c % uP) == 0) && (sent < nWords);
      userData = {8{8'hA5}};
      userCtl = 8'hFF;
      if (userEn) begin
        for (int k = 0; k < bytesPer; k++) begin
          userData[8*k +: 8] = bval(byteIdx + k, w);
          userCtl[k] = cval(byteIdx + k, w);
        end
        for (int q = 0; q < 2; q++) begin
          int first;
          first = byteIdx + bytesPer - 4 * (2 - q);
          if (q == 1 || bytesPer == 8) begin
            if (((byteIdx + bytesPer) % 4) == 0) begin
              if (q == 0) first = byteIdx;
              else first = byteIdx + bytesPer - 4;
              for (int k = 0; k < 4; k++) begin
                wd[8*k +: 8] = bval(first + k, w);
                wc[k] = cval(first + k, w);
              end
              expData[tail] = wd; expCtl[tail] = wc; expDone[tail] = edgeNo + 1;
              tail++;
            end
          end
        end
        byteIdx += bytesPer;
        sent++;
      end
      coreEn = ((c % cP) == cP - 1);
      prevCoreEn = coreEn;
      @(negedge clk);
    end
    chk(head == 16 && tail == 16, "R2 R10 all words delivered once", 64'(head), 64'd16);
  endtask

  initial begin
    rstN = 1'b0; widthSel = 2'b00; userEn = 1'b0; coreEn = 1'b0;
    userData = '0; userCtl = '0;
    for (int w = 0; w < 4; w++) runMode(w);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<50000", edgeNo);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule